// File: doc/BRIEF.md
# Configurable-Associativity Translation Lookaside Buffer

This block maps 32-bit virtual addresses onto physical addresses for 4 KB pages. A requester presents a lookup with a virtual address and a write flag. In the same cycle it gets back a hit, the physical address and the dirty state of the matching entry. On a miss the block raises a refill request naming the virtual page. An external page-walk unit later answers with a fill that carries the virtual page, the physical page and its dirty state.

A write that hits marks the entry dirty and asks the page table, through a dedicated strobe, to mark its own copy dirty. When the frame manager evicts a page, it sends an invalidate for that virtual page. Two parameters set the entry count and the organisation. Three free-running counters record lookups, hits and misses.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the three counters read zero.
- R2: A lookup hits when a valid entry holds its virtual page (address bits 31..12). On a hit, `lk_paddr` is the stored physical page in bits 31..12 with address bits 11..0 passed through unchanged, and `lk_dirty` gives the entry's dirty state from before this lookup. Both outputs are valid in the same cycle as `lk_valid`. On a miss, `lk_paddr` and `lk_dirty` are zero.
- R3: A lookup that misses drives `miss_req` with `miss_vpn` in the same cycle. A fill installs its mapping at the clock edge, and a lookup of that page in the next cycle hits.
- R4: A fill for a virtual page that is already resident rewrites that entry's physical page and dirty bit in place, and no other entry of the set is disturbed.
- R5: A write lookup that hits sets the entry's dirty bit and, in the same cycle, raises `pt_dirty_set` with `pt_dirty_vpn` equal to the looked-up page.
- R6: An entry is installed dirty when `fill_dirty` is set, or when the most recent missing lookup was a write to the same page.
- R7: The organisation code `ORG` selects the layout: 1 is direct-mapped, 2 is fully associative, 3 is 2-way and 4 is 4-way. The set index is the virtual page modulo the number of sets. `ENTRIES` must be a power of two of at least 2, and any other configuration stops elaboration.
- R8: A fill of a non-resident page goes into the lowest-numbered invalid way of its set. If the set has no invalid way, the fill replaces the least recently used entry. Hits and fills both count as uses.
- R9: An invalidate clears any entry holding `inv_vpn`. A lookup of that page in the same cycle misses. A fill of that page in the same cycle is dropped, and the invalidated way counts as free for a fill to the same set.
- R10: `cnt_lookup`, `cnt_hit` and `cnt_miss` each rise by one at the edge after a lookup, a hit or a miss respectively.
- R11: Within one cycle, a lookup sees the contents from before that cycle's fill. A hit in the same cycle counts as a use before the fill picks its victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_write | input | 1 | Lookup is a write |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Physical address on a hit, else zero |
| lk_dirty | output | 1 | Dirty state of the hit entry |
| miss_req | output | 1 | Refill request to the page walker |
| miss_vpn | output | 20 | Virtual page to walk |
| fill_valid | input | 1 | Fill from the page walker |
| fill_vpn | input | 20 | Virtual page of the fill |
| fill_ppn | input | 20 | Physical page of the fill |
| fill_dirty | input | 1 | Page-table dirty state of the fill |
| inv_valid | input | 1 | Invalidate from the frame manager |
| inv_vpn | input | 20 | Virtual page to invalidate |
| pt_dirty_set | output | 1 | Request to set the page-table dirty bit |
| pt_dirty_vpn | output | 20 | Page whose page-table dirty bit is set |
| cnt_lookup | output | CNT_W | Lookup count |
| cnt_hit | output | CNT_W | Hit count |
| cnt_miss | output | CNT_W | Miss count |

## Verification
The bound checker watches several properties on every cycle. The counters must always balance and must step correctly. The page offset must pass through untouched on a hit. A write hit must produce the page-table dirty request for the right page. A fill must be visible to a lookup one cycle later, and an invalidated page must miss both in its own cycle and in the next. Replacement order cannot be expressed as a short property, because it depends on a long history of hits, fills and invalidates. The same holds for the choice of free way after an invalidate, the merging of dirty state from an earlier write miss, and in-place refills. These are shown only by the bench's directed scenarios and its random traffic, compared against a recency-ordered reference.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = 20;

  localparam int ORG_DIRECT = 1;
  localparam int ORG_FULL   = 2;
  localparam int ORG_TWO    = 3;
  localparam int ORG_FOUR   = 4;

  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [PPN_W-1:0] ppn_t;

  function automatic vpn_t page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [VA_W-1:0] phys_addr(input ppn_t p, input logic [OFF_W-1:0] o);
    return {p, o};
  endfunction

  function automatic int ways_for(input int org, input int entries);
    case (org)
      ORG_DIRECT: return 1;
      ORG_FULL:   return entries;
      ORG_TWO:    return 2;
      ORG_FOUR:   return 4;
      default:    return 0;
    endcase
  endfunction

  function automatic bit cfg_ok(input int org, input int entries);
    int w;
    w = ways_for(org, entries);
    return (entries >= 2) && ((entries & (entries - 1)) == 0) && (w > 0) && (w <= entries);
  endfunction
endpackage

// File: rtl/tlb_set_match.sv
module tlb_set_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 17,
  parameter int WIX_W = 1
) (
  input  logic [WAYS-1:0]            way_vld,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            hit_vec,
  output logic [WIX_W-1:0]           hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_vld[w] && (way_tag[w] == key);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WIX_W'(w);
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SETS  = 8,
  parameter int WAYS  = 2,
  parameter int SIX_W = 3,
  parameter int WIX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic [SIX_W-1:0] a_set,
  input  logic [WIX_W-1:0] a_way,
  input  logic             b_en,
  input  logic [SIX_W-1:0] b_set,
  input  logic [WIX_W-1:0] b_way,
  input  logic [SIX_W-1:0] q_set,
  input  logic [WAYS-1:0]  q_free,
  output logic [WIX_W-1:0] victim
);
  localparam logic [WIX_W-1:0] OLDEST = WIX_W'(WAYS - 1);

  logic [WIX_W-1:0] age_q [SETS][WAYS];
  logic [WIX_W-1:0] age_m [SETS][WAYS];
  logic [WIX_W-1:0] age_d [SETS][WAYS];
  logic [WIX_W-1:0] ref_a, ref_b;

  // Age 0 is most recent; a touch ages every younger way by one.
  always_comb begin
    age_m = age_q;
    ref_a = age_q[a_set][a_way];
    if (a_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_m[a_set][w] < ref_a) age_m[a_set][w] = age_m[a_set][w] + 1'b1;
      end
      age_m[a_set][a_way] = '0;
    end
    age_d = age_m;
    ref_b = age_m[b_set][b_way];
    if (b_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_d[b_set][w] < ref_b) age_d[b_set][w] = age_d[b_set][w] + 1'b1;
      end
      age_d[b_set][b_way] = '0;
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_m[q_set][w] == OLDEST) victim = WIX_W'(w);
    end
    if (|q_free) begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (q_free[w]) victim = WIX_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WIX_W'(w);
    end else begin
      age_q <= age_d;
    end
  end
endmodule

// File: rtl/tlb_stat_ctr.sv
module tlb_stat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ORG     = 3,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [31:0]      lk_vaddr,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic [31:0]      lk_paddr,
  output logic             lk_dirty,
  output logic             miss_req,
  output logic [19:0]      miss_vpn,
  input  logic             fill_valid,
  input  logic [19:0]      fill_vpn,
  input  logic [19:0]      fill_ppn,
  input  logic             fill_dirty,
  input  logic             inv_valid,
  input  logic [19:0]      inv_vpn,
  output logic             pt_dirty_set,
  output logic [19:0]      pt_dirty_vpn,
  output logic [CNT_W-1:0] cnt_lookup,
  output logic [CNT_W-1:0] cnt_hit,
  output logic [CNT_W-1:0] cnt_miss
);
  localparam bit CFG_OK = cfg_ok(ORG, ENTRIES);
  localparam int WAYS   = CFG_OK ? ways_for(ORG, ENTRIES) : 1;
  localparam int SETS   = CFG_OK ? ENTRIES / WAYS : 1;
  localparam int IDX_W  = $clog2(SETS);
  localparam int SIX_W  = (IDX_W > 0) ? IDX_W : 1;
  localparam int WIX_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W  = VPN_W - IDX_W;
  localparam int NQ = 3;
  localparam int QL = 0;  // lookup port
  localparam int QF = 1;  // fill port
  localparam int QI = 2;  // invalidate port

  if (!CFG_OK) begin : g_bad_cfg
    $error("tlb_xlate: ENTRIES must be a power of two >= 2 and ORG one of 1..4");
  end

  function automatic logic [SIX_W-1:0] set_of(input vpn_t v);
    return SIX_W'(v % SETS);
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input vpn_t v);
    return TAG_W'(v >> IDX_W);
  endfunction

  // Entry storage
  logic             ent_v   [SETS][WAYS];
  logic             ent_d   [SETS][WAYS];
  logic [TAG_W-1:0] ent_tag [SETS][WAYS];
  ppn_t             ent_ppn [SETS][WAYS];

  // Three search ports share one matcher structure
  vpn_t             q_vpn    [NQ];
  logic [SIX_W-1:0] q_set    [NQ];
  logic [WAYS-1:0]  m_hitvec [NQ];
  logic [WIX_W-1:0] m_way    [NQ];
  logic             m_any    [NQ];

  assign q_vpn[QL] = page_of(lk_vaddr);
  assign q_vpn[QF] = fill_vpn;
  assign q_vpn[QI] = inv_vpn;

  for (genvar p = 0; p < NQ; p++) begin : g_port
    logic [WAYS-1:0]            vvec;
    logic [WAYS-1:0][TAG_W-1:0] tvec;
    assign q_set[p] = set_of(q_vpn[p]);
    always_comb begin
      for (int w = 0; w < WAYS; w++) begin
        vvec[w] = ent_v[q_set[p]][w];
        tvec[w] = ent_tag[q_set[p]][w];
      end
    end
    tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WIX_W(WIX_W)) u_match (
      .way_vld (vvec),
      .way_tag (tvec),
      .key     (tag_of(q_vpn[p])),
      .hit_vec (m_hitvec[p]),
      .hit_way (m_way[p])
    );
    assign m_any[p] = |m_hitvec[p];
  end

  // Named internal events
  logic inv_kills_lk, fill_go, fill_dirty_eff;
  logic [WIX_W-1:0] victim_way, fill_way;
  logic [WAYS-1:0]  fill_free;

  assign inv_kills_lk = inv_valid && (inv_vpn == q_vpn[QL]);
  assign lk_hit       = lk_valid && m_any[QL] && !inv_kills_lk;
  assign miss_req     = lk_valid && !lk_hit;
  assign miss_vpn     = q_vpn[QL];
  assign lk_paddr     = lk_hit ? phys_addr(ent_ppn[q_set[QL]][m_way[QL]], offset_of(lk_vaddr)) : '0;
  assign lk_dirty     = lk_hit && ent_d[q_set[QL]][m_way[QL]];
  assign pt_dirty_set = lk_hit && lk_write;
  assign pt_dirty_vpn = q_vpn[QL];

  // Remember the last miss so a later fill can inherit its write intent
  logic pend_vld, pend_wr;
  vpn_t pend_vpn;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_wr  <= 1'b0;
      pend_vpn <= '0;
    end else if (miss_req) begin
      pend_vld <= 1'b1;
      pend_wr  <= lk_write;
      pend_vpn <= q_vpn[QL];
    end
  end

  assign fill_go        = fill_valid && !(inv_valid && (inv_vpn == fill_vpn));
  assign fill_dirty_eff = fill_dirty || (pend_vld && pend_wr && (pend_vpn == fill_vpn));

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      fill_free[w] = !ent_v[q_set[QF]][w] ||
                     (inv_valid && (q_set[QI] == q_set[QF]) && m_hitvec[QI][w]);
    end
  end

  tlb_lru #(.SETS(SETS), .WAYS(WAYS), .SIX_W(SIX_W), .WIX_W(WIX_W)) u_lru (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_en   (lk_hit),
    .a_set  (q_set[QL]),
    .a_way  (m_way[QL]),
    .b_en   (fill_go),
    .b_set  (q_set[QF]),
    .b_way  (fill_way),
    .q_set  (q_set[QF]),
    .q_free (fill_free),
    .victim (victim_way)
  );

  assign fill_way = m_any[QF] ? m_way[QF] : victim_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ent_v[s][w] <= 1'b0;
    end else begin
      if (inv_valid && m_any[QI]) ent_v[q_set[QI]][m_way[QI]] <= 1'b0;
      if (fill_go)                ent_v[q_set[QF]][fill_way]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pt_dirty_set) ent_d[q_set[QL]][m_way[QL]] <= 1'b1;
    if (fill_go) begin
      ent_d[q_set[QF]][fill_way]   <= fill_dirty_eff;
      ent_tag[q_set[QF]][fill_way] <= tag_of(fill_vpn);
      ent_ppn[q_set[QF]][fill_way] <= fill_ppn;
    end
  end

  // Statistics
  logic [2:0]       ctr_inc;
  logic [CNT_W-1:0] ctr_val [3];
  assign ctr_inc = {miss_req, lk_hit, lk_valid};
  for (genvar c = 0; c < 3; c++) begin : g_ctr
    tlb_stat_ctr #(.W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ctr_inc[c]),
      .count (ctr_val[c])
    );
  end
  assign cnt_lookup = ctr_val[0];
  assign cnt_hit    = ctr_val[1];
  assign cnt_miss   = ctr_val[2];
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [31:0]      lk_vaddr,
  input logic             lk_write,
  input logic             lk_hit,
  input logic [31:0]      lk_paddr,
  input logic             lk_dirty,
  input logic             miss_req,
  input logic             fill_valid,
  input logic [19:0]      fill_vpn,
  input logic [19:0]      fill_ppn,
  input logic             inv_valid,
  input logic [19:0]      inv_vpn,
  input logic             pt_dirty_set,
  input logic [19:0]      pt_dirty_vpn,
  input logic [CNT_W-1:0] cnt_lookup,
  input logic [CNT_W-1:0] cnt_hit,
  input logic [CNT_W-1:0] cnt_miss
);
  assert_cnt_balance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_lookup == CNT_W'(cnt_hit + cnt_miss));

  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> cnt_lookup == CNT_W'($past(cnt_lookup) + 1));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[11:0] == lk_vaddr[11:0]);

  assert_fill_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(inv_valid && inv_vpn == fill_vpn)) ##1
    (lk_valid && lk_vaddr[31:12] == $past(fill_vpn) && !inv_valid)
    |-> lk_hit && lk_paddr[31:12] == $past(fill_ppn));

  assert_write_hit_pt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write) |-> pt_dirty_set && pt_dirty_vpn == lk_vaddr[31:12]);

  assert_dirty_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write) ##1 (lk_hit && lk_vaddr[31:12] == $past(lk_vaddr[31:12]) && !$past(fill_valid))
    |-> lk_dirty);

  assert_inv_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && inv_valid && lk_vaddr[31:12] == inv_vpn) |-> !lk_hit && miss_req);

  assert_inv_next_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid ##1 (lk_valid && lk_vaddr[31:12] == $past(inv_vpn) && !$past(fill_valid))
    |-> !lk_hit);
endmodule

bind tlb_xlate tlb_xlate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_vaddr     (lk_vaddr),
  .lk_write     (lk_write),
  .lk_hit       (lk_hit),
  .lk_paddr     (lk_paddr),
  .lk_dirty     (lk_dirty),
  .miss_req     (miss_req),
  .fill_valid   (fill_valid),
  .fill_vpn     (fill_vpn),
  .fill_ppn     (fill_ppn),
  .inv_valid    (inv_valid),
  .inv_vpn      (inv_vpn),
  .pt_dirty_set (pt_dirty_set),
  .pt_dirty_vpn (pt_dirty_vpn),
  .cnt_lookup   (cnt_lookup),
  .cnt_hit      (cnt_hit),
  .cnt_miss     (cnt_miss)
);

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
  localparam int ENTRIES = 16;
  localparam int ORG     = 3;
  localparam int CNT_W   = 32;
  localparam int B_WAYS  = (ORG == 1) ? 1 : (ORG == 2) ? ENTRIES : (ORG == 3) ? 2 : 4;
  localparam int B_SETS  = ENTRIES / B_WAYS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             lk_valid, lk_write, fill_valid, fill_dirty, inv_valid;
  logic [31:0]      lk_vaddr;
  logic [19:0]      fill_vpn, fill_ppn, inv_vpn;
  logic             lk_hit, lk_dirty, miss_req, pt_dirty_set;
  logic [31:0]      lk_paddr;
  logic [19:0]      miss_vpn, pt_dirty_vpn;
  logic [CNT_W-1:0] cnt_lookup, cnt_hit, cnt_miss;

  tlb_xlate #(.ENTRIES(ENTRIES), .ORG(ORG), .CNT_W(CNT_W)) u_tlb_xlate (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_dirty(lk_dirty),
    .miss_req(miss_req), .miss_vpn(miss_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_dirty(fill_dirty),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn),
    .pt_dirty_set(pt_dirty_set), .pt_dirty_vpn(pt_dirty_vpn),
    .cnt_lookup(cnt_lookup), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss)
  );

  // Reference: per set, a list ordered from most to least recently used
  typedef struct {
    int unsigned vpn;
    int unsigned ppn;
    bit          dirty;
  } ment_t;

  ment_t       mq [B_SETS][$];
  int unsigned m_lk = 0, m_hit = 0, m_miss = 0;
  bit          m_pv = 0, m_pw = 0;
  int unsigned m_pvpn = 0;
  int          compared = 0, mismatched = 0;
  string       phase = "R1 reset state";
  bit          done = 0;

  function automatic int find(input int s, input int unsigned v);
    for (int i = 0; i < mq[s].size(); i++)
      if (mq[s][i].vpn == v) return i;
    return -1;
  endfunction

  task automatic check(input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL [%s] %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic step(input bit lv, input int unsigned va, input bit wr,
                      input bit fv, input int unsigned fvpn, input int unsigned fppn, input bit fd,
                      input bit iv, input int unsigned ivpn);
    int unsigned lvpn, ep;
    int s, idx, k, sf, si;
    bit blocked, eh, ed, emiss, fde;
    ment_t e;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; lk_write = wr;
    fill_valid = fv; fill_vpn = 20'(fvpn); fill_ppn = 20'(fppn); fill_dirty = fd;
    inv_valid = iv; inv_vpn = 20'(ivpn);
    #1;
    lvpn    = va >> 12;
    s       = int'(lvpn % B_SETS);
    blocked = iv && (ivpn == lvpn);
    idx     = find(s, lvpn);
    eh      = lv && !blocked && (idx >= 0);
    ep      = eh ? ((mq[s][idx].ppn << 12) | (va & 32'hfff)) : 0;
    ed      = eh ? mq[s][idx].dirty : 1'b0;
    emiss   = lv && !eh;
    check("lk_hit", lk_hit, eh);
    check("lk_paddr", lk_paddr, ep);
    check("lk_dirty", lk_dirty, ed);
    check("miss_req", miss_req, emiss);
    if (emiss) check("miss_vpn", miss_vpn, lvpn);
    check("pt_dirty_set", pt_dirty_set, eh && wr);
    if (eh && wr) check("pt_dirty_vpn", pt_dirty_vpn, lvpn);
    check("cnt_lookup (R10)", cnt_lookup, m_lk);
    check("cnt_hit (R10)", cnt_hit, m_hit);
    check("cnt_miss (R10)", cnt_miss, m_miss);
    // Model the effect of the coming clock edge
    if (lv) begin
      m_lk++;
      if (eh) m_hit++; else m_miss++;
    end
    if (eh) begin
      e = mq[s][idx];
      if (wr) e.dirty = 1'b1;
      mq[s].delete(idx);
      mq[s].push_front(e);
    end
    if (iv) begin
      si = int'(ivpn % B_SETS);
      k  = find(si, ivpn);
      if (k >= 0) mq[si].delete(k);
    end
    if (fv && !(iv && ivpn == fvpn)) begin
      sf  = int'(fvpn % B_SETS);
      fde = fd || (m_pv && m_pw && m_pvpn == fvpn);
      k   = find(sf, fvpn);
      if (k >= 0) mq[sf].delete(k);
      else if (mq[sf].size() >= B_WAYS) void'(mq[sf].pop_back());
      e.vpn = fvpn; e.ppn = fppn; e.dirty = fde;
      mq[sf].push_front(e);
    end
    if (emiss) begin
      m_pv = 1'b1; m_pw = wr; m_pvpn = lvpn;
    end
  endtask

  task automatic look(input int unsigned va, input bit wr);
    step(1'b1, va, wr, 1'b0, 0, 0, 1'b0, 1'b0, 0);
  endtask
  task automatic fill(input int unsigned v, input int unsigned p, input bit d);
    step(1'b0, 0, 1'b0, 1'b1, v, p, d, 1'b0, 0);
  endtask
  task automatic inval(input int unsigned v);
    step(1'b0, 0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b1, v);
  endtask

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; lk_vaddr = 0; lk_write = 0;
    fill_valid = 0; fill_vpn = 0; fill_ppn = 0; fill_dirty = 0;
    inv_valid = 0; inv_vpn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    phase = "R1 reset state";
    look(32'h0000_1000, 0);
    look(32'h00ab_c123, 1);

    phase = "R6 write-miss fill";
    fill(20'habc, 20'h00011, 0);
    look(32'h00ab_c456, 0);
    look(32'h0000_7000, 0);
    fill(20'h7, 20'h00022, 1);
    look(32'h0000_7010, 0);

    phase = "R2 translate";
    fill(20'h1, 20'h00777, 0);
    look(32'h0000_1abc, 0);
    look(32'h0000_1ffc, 0);

    phase = "R3 refill";
    look(32'h0000_2004, 0);
    fill(20'h2, 20'h00042, 0);
    look(32'h0000_2004, 0);

    phase = "R5 write hit";
    look(32'h0000_1008, 1);
    look(32'h0000_1008, 0);

    phase = "R4 in-place fill";
    fill(20'h9, 20'h00888, 0);
    fill(20'h1, 20'h00999, 0);
    look(32'h0000_9000, 0);
    look(32'h0000_1000, 0);

    phase = "R7 set mapping";
    fill(20'h5, 20'h00105, 0);
    fill(20'hd, 20'h0010d, 0);
    fill(20'h15, 20'h00115, 0);
    fill(20'h6, 20'h00106, 0);
    look(32'h0000_5000, 0);
    look(32'h0000_d000, 0);
    look(32'h0001_5000, 0);
    look(32'h0000_6000, 0);

    phase = "R8 replacement";
    fill(20'h3, 20'h00203, 0);
    fill(20'hb, 20'h0020b, 0);
    look(32'h0000_3000, 0);
    fill(20'h13, 20'h00213, 0);
    look(32'h0000_b000, 0);
    look(32'h0000_3000, 0);
    inval(20'h3);
    fill(20'h1b, 20'h0021b, 0);
    look(32'h0001_3000, 0);
    look(32'h0001_b000, 0);

    phase = "R9 invalidate";
    inval(20'h13);
    look(32'h0001_3000, 0);
    step(1'b1, 32'h0001_b000, 1'b0, 1'b0, 0, 0, 1'b0, 1'b1, 20'h1b);
    look(32'h0001_b000, 0);
    step(1'b0, 0, 1'b0, 1'b1, 20'h20, 20'h00320, 1'b0, 1'b1, 20'h20);
    look(32'h0002_0000, 0);
    fill(20'h2c, 20'h0032c, 0);
    fill(20'h24, 20'h00324, 0);
    step(1'b0, 0, 1'b0, 1'b1, 20'h34, 20'h00334, 1'b0, 1'b1, 20'h2c);
    look(32'h0002_4000, 0);
    look(32'h0003_4000, 0);

    phase = "R11 same-cycle order";
    step(1'b1, 32'h0002_1000, 1'b0, 1'b1, 20'h21, 20'h00421, 1'b0, 1'b0, 0);
    look(32'h0002_1000, 0);
    fill(20'h4, 20'h00404, 0);
    fill(20'hc, 20'h0040c, 0);
    step(1'b1, 32'h0000_4000, 1'b1, 1'b1, 20'h14, 20'h00414, 1'b0, 1'b0, 0);
    look(32'h0000_4000, 0);
    look(32'h0000_c000, 0);
    look(32'h0001_4000, 0);

    phase = "R10 mixed traffic";
    for (int n = 0; n < 3000; n++) begin
      int unsigned rv, rf, ri;
      rv = $urandom_range(0, 23);
      rf = $urandom_range(0, 23);
      ri = $urandom_range(0, 23);
      step($urandom_range(0, 3) != 0, (rv << 12) | ($urandom_range(0, 1023) << 2),
           $urandom_range(0, 2) == 0,
           $urandom_range(0, 2) == 0, rf, $urandom_range(0, 20'hfffff), $urandom_range(0, 3) == 0,
           $urandom_range(0, 7) == 0, ri);
    end
    step(1'b0, 0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL [watchdog] run did not finish: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule